// File: doc/BRIEF.md
# Serial Debug Port with Handshake Pulses

This block is the target side of a synchronous serial debug link. It lives entirely in the processor clock domain. An external controller drives a slow serial clock and a serial data line. The block oversamples both, receives 8-bit command words, and then reads or writes one entry of a 16 x 24-bit register file. The processor core reaches the same register file through a plain parallel port.

A single output line carries two kinds of traffic. The first is the read data, most significant bit first. The second is a set of active-low acknowledge pulses, each four processor clocks long. A pulse marks entry into debug mode, read data ready to shift, readiness to accept write data, and completion of a write. Input bits are taken on falling edges of the serial clock, and output bits advance on rising edges.

Top module: `dbg_serial_port`

## Requirements
- R1: After reset, sdo_o is high and every register reads zero on the core port.
- R2: While dbg_mode_i is low, sdo_o stays high whatever sclk_i and sdi_i do, and no transfer takes place.
- R3: When dbg_mode_i rises, sdo_o goes low for exactly 4 processor clocks and then returns high, and the port waits for a command.
- R4: A command is 8 bits, sampled on falling serial clock edges, first bit = bit 7. Bit 7 = 1 means read and 0 means write. Bits 3:0 give the register address, and bits 6:4 are ignored.
- R5: After a read command, sdo_o pulses low for 4 clocks and then shows bit 23 of the data. Each rising serial edge that follows a falling edge of the read presents the next lower bit. After the 24th falling edge, sdo_o returns high and a new command is awaited.
- R6: Read data comes from the register named by the most recent command and includes any earlier core or serial write.
- R7: After a write command, sdo_o pulses low for 4 clocks. The port then takes 24 bits, MSB first, on falling edges and writes them to the addressed register. A second 4-clock low pulse starts in the same clock as that write.
- R8: Taking dbg_mode_i low at any point sets sdo_o high on the next clock and drops the transfer without writing. A later rise restarts with the R3 pulse and a fresh command.
- R9: core_rdata_o shows the register at core_addr_i. A core write lands on the next clock, and a serial write to the same address in the same clock wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_mode_i | input | 1 | High while the core is in debug mode |
| sclk_i | input | 1 | External serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in, asynchronous |
| sdo_o | output | 1 | Serial data out and acknowledge pulses |
| core_addr_i | input | 4 | Core register address |
| core_we_i | input | 1 | Core write enable |
| core_wdata_i | input | 24 | Core write data |
| core_rdata_o | output | 24 | Register at core_addr_i |

## Verification
The controller's sequencing state is visible only through sdo_o, so most faults show up as a handshake pulse that is missing, misplaced, or the wrong length. A wrong bit counter shifts the ack to the wrong serial edge, or leaves the port stuck in a data phase, and this appears within one command or word. A wrong shift direction or a wrong snapshot point gives a corrupted read word within the 24 serial clocks of that read. A bad address latch or write strobe shows at core_rdata_o one clock after the write ack begins.

// File: rtl/dbg_port_pkg.sv
package dbg_port_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_ACK, ST_CMD, ST_RD, ST_WR} dbg_state_e;
endpackage

// File: rtl/dbg_sync_edge.sv
module dbg_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic rise_o,
  output logic fall_o,
  output logic sdi_o
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] sclk_q, sdi_q;
  logic         sclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q      <= '0;
      sdi_q       <= '0;
      sclk_prev_q <= 1'b0;
    end else begin
      sclk_q      <= {sclk_q[MSB-1:0], sclk_i};
      sdi_q       <= {sdi_q[MSB-1:0], sdi_i};
      sclk_prev_q <= sclk_q[MSB];
    end
  end

  // data and clock share the synchronizer depth, so sdi_o lines up with the edge
  assign rise_o = sclk_q[MSB] & ~sclk_prev_q;
  assign fall_o = ~sclk_q[MSB] & sclk_prev_q;
  assign sdi_o  = sdi_q[MSB];
endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] s_addr_i,
  input  logic              s_we_i,
  input  logic [DATA_W-1:0] s_wdata_i,
  output logic [DATA_W-1:0] s_rdata_o,
  input  logic [ADDR_W-1:0] c_addr_i,
  input  logic              c_we_i,
  input  logic [DATA_W-1:0] c_wdata_i,
  output logic [DATA_W-1:0] c_rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (c_we_i) mem_q[c_addr_i] <= c_wdata_i;
      // serial port last: wins on an address collision
      if (s_we_i) mem_q[s_addr_i] <= s_wdata_i;
    end
  end

  assign s_rdata_o = mem_q[s_addr_i];
  assign c_rdata_o = mem_q[c_addr_i];
endmodule

// File: rtl/dbg_port_ctrl.sv
module dbg_port_ctrl
  import dbg_port_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int CMD_W   = 8,
  parameter int ADDR_W  = 4,
  parameter int ACK_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbg_mode_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              sdo_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int ACK_W = $clog2(ACK_CYC + 1);
  localparam int RD_FLAG = CMD_W - 2;  // position of command MSB one bit before the last shift

  dbg_state_e        state_q, next_q;
  logic [ACK_W-1:0]  ack_cnt_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      next_q    <= ST_CMD;
      ack_cnt_q <= '0;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      addr_q    <= '0;
      we_q      <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (!dbg_mode_i) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            state_q   <= ST_ACK;
            next_q    <= ST_CMD;
            ack_cnt_q <= '0;
          end
          ST_ACK: begin
            if (ack_cnt_q == ACK_W'(ACK_CYC - 1)) begin
              state_q   <= next_q;
              bit_cnt_q <= '0;
              if (next_q == ST_RD) shreg_q <= rdata_i;  // snapshot at end of pulse
            end else begin
              ack_cnt_q <= ack_cnt_q + 1'b1;
            end
          end
          ST_CMD: if (fall_i) begin
            shreg_q   <= {shreg_q[DATA_W-2:0], sdi_i};
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == CNT_W'(CMD_W - 1)) begin
              addr_q    <= {shreg_q[ADDR_W-2:0], sdi_i};
              next_q    <= shreg_q[RD_FLAG] ? ST_RD : ST_WR;
              state_q   <= ST_ACK;
              ack_cnt_q <= '0;
            end
          end
          ST_RD: begin
            if (rise_i && bit_cnt_q != '0) shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
            if (fall_i) begin
              if (bit_cnt_q == CNT_W'(DATA_W - 1)) begin
                state_q   <= ST_CMD;
                bit_cnt_q <= '0;
              end else begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end
            end
          end
          ST_WR: if (fall_i) begin
            shreg_q   <= {shreg_q[DATA_W-2:0], sdi_i};
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == CNT_W'(DATA_W - 1)) begin
              we_q      <= 1'b1;
              next_q    <= ST_CMD;
              state_q   <= ST_ACK;
              ack_cnt_q <= '0;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_ACK:  sdo_o = 1'b0;
      ST_RD:   sdo_o = shreg_q[DATA_W-1];
      default: sdo_o = 1'b1;
    endcase
  end

  assign addr_o  = addr_q;
  assign we_o    = we_q;
  assign wdata_o = shreg_q;

  a_r3_ack_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ACK |-> ack_cnt_q < ACK_W'(ACK_CYC));

  a_r4_cmd_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CMD |-> bit_cnt_q < CNT_W'(CMD_W));

  a_r5_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD && !rise_i && dbg_mode_i) |=> (state_q != ST_RD || $stable(sdo_o)));

  a_r7_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q);

  a_r7_we_in_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> (state_q == ST_ACK && ack_cnt_q == '0));
endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port #(
  parameter int DATA_W  = 24,
  parameter int CMD_W   = 8,
  parameter int ADDR_W  = 4,
  parameter int ACK_CYC = 4,
  parameter int STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbg_mode_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic [ADDR_W-1:0] core_addr_i,
  input  logic              core_we_i,
  input  logic [DATA_W-1:0] core_wdata_i,
  output logic [DATA_W-1:0] core_rdata_o
);
  logic              rise, fall, sdi_s, s_we;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_wdata, s_rdata;

  dbg_sync_edge #(.STAGES(STAGES)) i_sync (
    .clk_i, .rst_ni, .sclk_i, .sdi_i,
    .rise_o(rise), .fall_o(fall), .sdi_o(sdi_s)
  );

  dbg_port_ctrl #(
    .DATA_W(DATA_W), .CMD_W(CMD_W), .ADDR_W(ADDR_W), .ACK_CYC(ACK_CYC)
  ) i_ctrl (
    .clk_i, .rst_ni, .dbg_mode_i,
    .rise_i(rise), .fall_i(fall), .sdi_i(sdi_s),
    .rdata_i(s_rdata), .addr_o(s_addr), .we_o(s_we), .wdata_o(s_wdata),
    .sdo_o
  );

  dbg_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni,
    .s_addr_i(s_addr), .s_we_i(s_we), .s_wdata_i(s_wdata), .s_rdata_o(s_rdata),
    .c_addr_i(core_addr_i), .c_we_i(core_we_i), .c_wdata_i(core_wdata_i),
    .c_rdata_o(core_rdata_o)
  );

  a_r2_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_mode_i |=> sdo_o);

  a_r8_abort_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_mode_i |=> !s_we);
endmodule

// File: tb/test_dbg_serial_port.sv
module test_dbg_serial_port;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        dbg_mode = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic        sdo;
  logic [3:0]  core_addr = '0;
  logic        core_we = 1'b0;
  logic [23:0] core_wdata = '0, core_rdata;
  int          n_checks = 0, n_errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dbg_serial_port i_dbg_serial_port (
    .clk_i(clk), .rst_ni, .dbg_mode_i(dbg_mode), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .core_addr_i(core_addr), .core_we_i(core_we),
    .core_wdata_i(core_wdata), .core_rdata_o(core_rdata)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic core_wr(input logic [3:0] a, input logic [23:0] d);
    core_addr = a; core_wdata = d; core_we = 1'b1;
    tick(1);
    core_we = 1'b0;
  endtask

  task automatic core_rd(input logic [3:0] a, output logic [23:0] d);
    core_addr = a;
    tick(1);
    d = core_rdata;
  endtask

  // ends right after the last falling edge
  task automatic send_bits(input logic [23:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i]; sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
      if (i != 0) tick(4);
    end
  endtask

  // 4 lows then after_val on sdo
  task automatic wait_ack(input logic after_val, input string tag);
    int t = 0;
    bit ok = 1'b1;
    logic last;
    while (sdo && t < 20) begin tick(1); t++; end
    if (sdo) ok = 1'b0;
    for (int k = 1; k < 4; k++) begin
      tick(1);
      if (sdo !== 1'b0) ok = 1'b0;
    end
    tick(1);
    last = sdo;
    if (last !== after_val) ok = 1'b0;
    check(ok, tag, {23'd0, last}, {23'd0, after_val});
  endtask

  task automatic ser_read(input logic [7:0] cmd, input logic [23:0] exp, input string tag);
    logic [23:0] got = '0;
    send_bits({16'd0, cmd}, 8);
    wait_ack(exp[23], {tag, " read ack"});
    for (int i = 23; i >= 0; i--) begin
      sclk = 1'b1;
      tick(4);
      got[i] = sdo;
      sclk = 1'b0;
      tick(4);
    end
    check(got === exp, {tag, " read word"}, got, exp);
    tick(2);
    check(sdo === 1'b1, "R5 high after read", {23'd0, sdo}, 24'd1);
  endtask

  task automatic ser_write(input logic [7:0] cmd, input logic [23:0] d, input string tag);
    send_bits({16'd0, cmd}, 8);
    wait_ack(1'b1, {tag, " write-ready ack"});
    send_bits(d, 24);
    wait_ack(1'b1, {tag, " write-done ack"});
  endtask

  task automatic t_reset;
    logic [23:0] d;
    check(sdo === 1'b1, "R1 sdo after reset", {23'd0, sdo}, 24'd1);
    core_rd(4'd0, d);  check(d === 24'd0, "R1 reg0 zero", d, 24'd0);
    core_rd(4'd15, d); check(d === 24'd0, "R1 reg15 zero", d, 24'd0);
  endtask

  task automatic t_core;
    logic [23:0] d;
    core_wr(4'd2, 24'hA5C396);
    core_rd(4'd2, d); check(d === 24'hA5C396, "R9 core write/read", d, 24'hA5C396);
    core_wr(4'd7, 24'h3C0F81);
    core_wr(4'd3, 24'h00FF00);
    core_wr(4'd12, 24'h800001);
  endtask

  task automatic t_idle;
    bit ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      sdi = i[0]; sclk = 1'b1; tick(4);
      if (sdo !== 1'b1) ok = 1'b0;
      sclk = 1'b0; tick(4);
      if (sdo !== 1'b1) ok = 1'b0;
    end
    check(ok, "R2 idle high outside debug", {23'd0, ok}, 24'd1);
  endtask

  task automatic t_entry;
    dbg_mode = 1'b1;
    wait_ack(1'b1, "R3 entry ack");
  endtask

  task automatic t_reads;
    ser_read(8'h82, 24'hA5C396, "R5 R6 reg2");
    ser_read(8'h87, 24'h3C0F81, "R5 R6 reg7 msb0");
  endtask

  task automatic t_write;
    logic [23:0] d;
    ser_write(8'h09, 24'h5A1234, "R7 reg9");
    core_rd(4'd9, d); check(d === 24'h5A1234, "R7 written value", d, 24'h5A1234);
    ser_read(8'h89, 24'h5A1234, "R6 readback reg9");
  endtask

  task automatic t_ignored;
    logic [23:0] d;
    ser_read(8'hF3, 24'h00FF00, "R4 bits 6:4 set read reg3");
    ser_write(8'h7B, 24'hC0FFEE, "R4 bits 6:4 set write");
    core_rd(4'd11, d); check(d === 24'hC0FFEE, "R4 write reg11", d, 24'hC0FFEE);
    core_rd(4'd3, d);  check(d === 24'h00FF00, "R4 reg3 untouched", d, 24'h00FF00);
  endtask

  task automatic t_abort;
    logic [23:0] d;
    // abort mid-read while sdo is low (reg12 = 800001, bits 22..1 zero)
    send_bits(24'h8C, 8);
    wait_ack(1'b1, "R8 read ack reg12");
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
    end
    check(sdo === 1'b0, "R8 pre-abort data low", {23'd0, sdo}, 24'd0);
    dbg_mode = 1'b0;
    tick(1);
    check(sdo === 1'b1, "R8 high after abort", {23'd0, sdo}, 24'd1);
    tick(4);
    // abort mid-write
    t_entry();
    send_bits(24'h05, 8);
    wait_ack(1'b1, "R8 write-ready ack");
    send_bits(24'hFFFFFF, 12);
    dbg_mode = 1'b0;
    tick(8);
    core_rd(4'd5, d); check(d === 24'd0, "R8 no write on abort", d, 24'd0);
    dbg_mode = 1'b1;
    wait_ack(1'b1, "R8 re-entry ack");
    ser_read(8'h82, 24'hA5C396, "R8 fresh command");
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    t_reset();
    t_core();
    t_idle();
    t_entry();
    t_reads();
    t_write();
    t_ignored();
    t_abort();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule